// File: doc/BRIEF.md
# Branch and Skip Program Counter Sequencer

This block decides where a processor with 16-bit instruction words fetches next. Each cycle the decoder may present one resolved instruction. It gives the address of that instruction, its control class, an offset field, the processor status byte, a status-bit selector with a polarity, the outcome of a skip test and the size of the instruction that follows. One clock later the sequencer produces the next program counter and a stall count. The stall count is the number of cycles the instruction takes, minus one. The fetch stage uses it to insert that many bubbles.

There are four control classes. Sequential flow steps to the following word. A relative jump always redirects. A conditional branch tests one status bit, or the signed-less-than combination of negative and overflow, against a chosen polarity. A skip hops over the next instruction and accounts for whether that instruction is one word or two words long. Program memory is 4K words, so all arithmetic on addresses wraps at 4096.

The block holds no program counter of its own. It is a single registered decision stage. When no instruction is presented, it keeps its last result and drops its valid flag. The style keeps its state-register and output-process split, but the register stage is only a valid flag plus the held result. The control class takes the place of a state enum.

Top module: `pcseq_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first clock after it, out_valid is 0, next_pc is 0 and stall is 0.
- R2: A request sampled with in_valid high gives out_valid high with its result on the next clock. A cycle with in_valid low gives out_valid low on the next clock, and next_pc and stall keep their previous values.
- R3: Class code 0 (sequential) gives next_pc = pc_in + 1 and stall 0.
- R4: Class code 1 (relative jump) treats offset[11:0] as a signed word offset and gives next_pc = pc_in + offset + 1 with stall 1.
- R5: Class code 2 (conditional branch) selects status[bit_sel], with bit positions 0 carry, 1 zero, 2 negative, 3 overflow, 5 half carry, 6 T and 7 interrupt enable. The branch is taken when that bit equals take_if_set.
- R6: For a branch with bit_sel 4, the tested value is status[2] XOR status[3], and the stored status[4] has no effect. With take_if_set 0 this is signed greater-or-equal; with 1 it is signed less-than.
- R7: A taken branch uses only offset[6:0] as a signed word offset, giving next_pc = pc_in + offset + 1 with stall 1. offset[11:7] has no effect.
- R8: A branch that is not taken gives next_pc = pc_in + 1 and stall 0.
- R9: Class code 3 (skip) gives next_pc = pc_in + 1 with stall 0 when skip_hit is 0. When skip_hit is 1 it gives pc_in + 2 with stall 1 if next_is_long is 0, and pc_in + 3 with stall 2 if next_is_long is 1.
- R10: All next_pc results wrap modulo 4096, both forward past 4095 and backward below 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A resolved instruction is presented this cycle |
| pc_in | input | 12 | Word address of the presented instruction |
| ctl_class | input | 2 | 0 sequential, 1 jump, 2 branch, 3 skip |
| offset | input | 12 | Signed word offset; a branch uses bits 6:0 only |
| status | input | 8 | Processor status byte |
| bit_sel | input | 3 | Status bit tested by a branch |
| take_if_set | input | 1 | Branch polarity: 1 taken when the bit is 1, 0 taken when it is 0 |
| skip_hit | input | 1 | The skip condition holds |
| next_is_long | input | 1 | The instruction after this one is two words long |
| out_valid | output | 1 | next_pc and stall hold a fresh result |
| next_pc | output | 12 | Address to fetch next |
| stall | output | 2 | Extra cycles taken by the instruction |

## Verification
The properties assume that every input is a defined value whenever in_valid is high. They also assume that skip_hit and next_is_long are meaningful only for the skip class and the status fields only for the branch class. Each property is therefore gated by the class seen one cycle earlier. The stimulus changes inputs only at the falling edge and never leaves them undefined. It fills the fields that a class ignores with arbitrary values, so that any leak from an ignored field shows up at the ports.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    // Control class presented by the decoder
    typedef enum logic [1:0] {
        CLS_SEQ    = 2'd0,
        CLS_JUMP   = 2'd1,
        CLS_BRANCH = 2'd2,
        CLS_SKIP   = 2'd3
    } ctl_class_e;

    // Status byte positions that the branch logic depends on
    localparam int unsigned NEG_POS  = 2;
    localparam int unsigned OVF_POS  = 3;
    localparam int unsigned SIGN_POS = 4;

    localparam int unsigned STALL_W  = 2;

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond #(
    parameter int unsigned STAT_W = 8,
    localparam int unsigned SEL_W = $clog2(STAT_W)
) (
    input  logic [STAT_W-1:0] status,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              take_if_set,
    output logic              taken
);
    import pcseq_pkg::*;

    logic [STAT_W-1:0] eff_status;

    // The signed-test position is rebuilt from negative and overflow,
    // so a stale stored value cannot steer a branch.
    always_comb begin
        eff_status = status;
        eff_status[SIGN_POS] = status[NEG_POS] ^ status[OVF_POS];
    end

    assign taken = (eff_status[bit_sel] == take_if_set);

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target #(
    parameter int unsigned PC_W  = 12,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] off_ext;

    generate
        if (OFF_W < PC_W) begin : g_extend
            assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        end else begin : g_trim
            assign off_ext = off[PC_W-1:0];
        end
    endgenerate

    // The sum wraps at 2**PC_W words
    assign target = pc + off_ext + PC_W'(1);

endmodule

// File: rtl/pcseq_skip.sv
module pcseq_skip #(
    parameter int unsigned PC_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    input  logic             skip_hit,
    input  logic             next_is_long,
    output logic [PC_W-1:0]  skip_pc,
    output logic [pcseq_pkg::STALL_W-1:0] skip_stall
);
    import pcseq_pkg::*;

    always_comb begin
        if (!skip_hit) begin
            skip_pc    = pc + PC_W'(1);
            skip_stall = STALL_W'(0);
        end else if (next_is_long) begin
            skip_pc    = pc + PC_W'(3);
            skip_stall = STALL_W'(2);
        end else begin
            skip_pc    = pc + PC_W'(2);
            skip_stall = STALL_W'(1);
        end
    end

endmodule

// File: rtl/pcseq_unit.sv
module pcseq_unit #(
    parameter int unsigned PC_W   = 12,
    parameter int unsigned JOFF_W = 12,
    parameter int unsigned BOFF_W = 7,
    parameter int unsigned STAT_W = 8,
    localparam int unsigned SEL_W = $clog2(STAT_W),
    localparam int unsigned ST_W  = pcseq_pkg::STALL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [1:0]        ctl_class,
    input  logic [JOFF_W-1:0] offset,
    input  logic [STAT_W-1:0] status,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              take_if_set,
    input  logic              skip_hit,
    input  logic              next_is_long,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic [ST_W-1:0]   stall
);
    import pcseq_pkg::*;

    ctl_class_e      cls;
    logic            br_taken;
    logic [PC_W-1:0] jump_pc, branch_pc, skip_pc, seq_pc;
    logic [ST_W-1:0] skip_stall;
    logic [PC_W-1:0] nxt_pc;
    logic [ST_W-1:0] nxt_stall;

    assign cls    = ctl_class_e'(ctl_class);
    assign seq_pc = pc_in + PC_W'(1);

    pcseq_cond #(.STAT_W(STAT_W)) i_cond (
        .status      (status),
        .bit_sel     (bit_sel),
        .take_if_set (take_if_set),
        .taken       (br_taken)
    );

    pcseq_target #(.PC_W(PC_W), .OFF_W(JOFF_W)) i_jump_tgt (
        .pc     (pc_in),
        .off    (offset),
        .target (jump_pc)
    );

    pcseq_target #(.PC_W(PC_W), .OFF_W(BOFF_W)) i_branch_tgt (
        .pc     (pc_in),
        .off    (offset[BOFF_W-1:0]),
        .target (branch_pc)
    );

    pcseq_skip #(.PC_W(PC_W)) i_skip (
        .pc           (pc_in),
        .skip_hit     (skip_hit),
        .next_is_long (next_is_long),
        .skip_pc      (skip_pc),
        .skip_stall   (skip_stall)
    );

    // Output selection by control class
    always_comb begin
        unique case (cls)
            CLS_JUMP: begin
                nxt_pc    = jump_pc;
                nxt_stall = ST_W'(1);
            end
            CLS_BRANCH: begin
                nxt_pc    = br_taken ? branch_pc : seq_pc;
                nxt_stall = br_taken ? ST_W'(1) : ST_W'(0);
            end
            CLS_SKIP: begin
                nxt_pc    = skip_pc;
                nxt_stall = skip_stall;
            end
            default: begin
                nxt_pc    = seq_pc;
                nxt_stall = ST_W'(0);
            end
        endcase
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            stall     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                next_pc <= nxt_pc;
                stall   <= nxt_stall;
            end
        end
    end

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int unsigned PC_W = 12,
    parameter int unsigned ST_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [PC_W-1:0] pc_in,
    input logic [1:0]      ctl_class,
    input logic            skip_hit,
    input logic            next_is_long,
    input logic            out_valid,
    input logic [PC_W-1:0] next_pc,
    input logic [ST_W-1:0] stall
);
    // R2: valid follows the request by one clock
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(next_pc) && $stable(stall)));
    // R3: sequential step
    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd0) |=>
            (next_pc == $past(pc_in) + PC_W'(1) && stall == ST_W'(0)));
    // R4: a jump always costs one extra cycle
    p_jump_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd1) |=> (stall == ST_W'(1)));
    // R7, R8: a branch costs at most one extra cycle, and none when it falls through
    p_branch_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd2) |=>
            ((stall == ST_W'(0) && next_pc == $past(pc_in) + PC_W'(1)) ||
             stall == ST_W'(1)));
    // R9: skip lengths
    p_skip_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd3 && skip_hit && next_is_long) |=>
            (next_pc == $past(pc_in) + PC_W'(3) && stall == ST_W'(2)));
    p_skip_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd3 && skip_hit && !next_is_long) |=>
            (next_pc == $past(pc_in) + PC_W'(2) && stall == ST_W'(1)));
    p_skip_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_class == 2'd3 && !skip_hit) |=>
            (next_pc == $past(pc_in) + PC_W'(1) && stall == ST_W'(0)));
    // R1: reset clears the result
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && next_pc == '0 && stall == '0));

endmodule

bind pcseq_unit pcseq_checker #(.PC_W(PC_W), .ST_W(ST_W)) i_pcseq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .pc_in        (pc_in),
    .ctl_class    (ctl_class),
    .skip_hit     (skip_hit),
    .next_is_long (next_is_long),
    .out_valid    (out_valid),
    .next_pc      (next_pc),
    .stall        (stall)
);

// File: tb/test_pcseq_unit.sv
`timescale 1ns/1ps
module test_pcseq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] pc_in = '0;
    logic [1:0]  ctl_class = '0;
    logic [11:0] offset = '0;
    logic [7:0]  status = '0;
    logic [2:0]  bit_sel = '0;
    logic        take_if_set = 1'b0;
    logic        skip_hit = 1'b0;
    logic        next_is_long = 1'b0;
    logic        out_valid;
    logic [11:0] next_pc;
    logic [1:0]  stall;

    int total = 0;
    int bad = 0;

    // Reference state
    int    exp_valid = 0;
    int    exp_pc = 0;
    int    exp_stall = 0;
    string exp_tag = "R1";

    always #4 clk = ~clk;

    pcseq_unit i_pcseq_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
        .ctl_class(ctl_class), .offset(offset), .status(status),
        .bit_sel(bit_sel), .take_if_set(take_if_set), .skip_hit(skip_hit),
        .next_is_long(next_is_long), .out_valid(out_valid),
        .next_pc(next_pc), .stall(stall)
    );

    task automatic compare();
        total++;
        if (int'(out_valid) != exp_valid || int'(next_pc) != exp_pc ||
            int'(stall) != exp_stall) begin
            bad++;
            $display("FAIL %s: got valid=%0d pc=%0d stall=%0d, expected valid=%0d pc=%0d stall=%0d",
                     exp_tag, out_valid, next_pc, stall, exp_valid, exp_pc, exp_stall);
        end
    endtask

    // Behavioural model of one request, kept in integers
    task automatic apply(input bit v, input int pc, input int cls, input int off,
                         input int st, input int sel, input bit pol,
                         input bit hit, input bit lng);
        int bval;
        int soff;
        @(negedge clk);
        compare();
        in_valid = v; pc_in = 12'(pc); ctl_class = 2'(cls); offset = 12'(off);
        status = 8'(st); bit_sel = 3'(sel); take_if_set = pol;
        skip_hit = hit; next_is_long = lng;
        if (!v) begin
            exp_valid = 0; exp_tag = "R2 idle hold";
            return;
        end
        exp_valid = 1;
        case (cls)
            0: begin exp_pc = (pc + 1) % 4096; exp_stall = 0; exp_tag = "R3 sequential"; end
            1: begin
                soff = off % 4096;
                if (soff >= 2048) soff -= 4096;
                exp_pc = (pc + soff + 1 + 8192) % 4096; exp_stall = 1; exp_tag = "R4 jump";
            end
            2: begin
                if (sel == 4) bval = ((st >> 2) & 1) ^ ((st >> 3) & 1);
                else          bval = (st >> sel) & 1;
                if (bval == int'(pol)) begin
                    soff = off % 128;
                    if (soff >= 64) soff -= 128;
                    exp_pc = (pc + soff + 1 + 8192) % 4096; exp_stall = 1;
                    exp_tag = (sel == 4) ? "R6 signed taken" : "R5/R7 branch taken";
                end else begin
                    exp_pc = (pc + 1) % 4096; exp_stall = 0;
                    exp_tag = (sel == 4) ? "R6 signed not taken" : "R5/R8 branch not taken";
                end
            end
            default: begin
                if (!hit)     begin exp_pc = (pc + 1) % 4096; exp_stall = 0; end
                else if (lng) begin exp_pc = (pc + 3) % 4096; exp_stall = 2; end
                else          begin exp_pc = (pc + 2) % 4096; exp_stall = 1; end
                exp_tag = "R9 skip";
            end
        endcase
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();                 // R1 during reset
        rst_n = 1'b1;
        // R1: first compare after release still shows reset values
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 and R10 forward wrap
        apply(1, 100, 0, 12'hABC, 8'hFF, 5, 1, 1, 1);
        apply(1, 4095, 0, 0, 0, 0, 0, 0, 0);
        // R4 jump: back by one, wrap forward, wrap backward
        apply(1, 200, 1, 12'hFFF, 0, 0, 0, 0, 0);
        apply(1, 4090, 1, 20, 0, 0, 0, 0, 0);
        apply(1, 3, 1, 12'h800, 0, 0, 0, 0, 0);
        // R2 idle holds the last result
        apply(0, 77, 2, 5, 8'hFF, 1, 1, 1, 1);
        apply(0, 78, 3, 5, 8'hFF, 1, 1, 1, 1);
        // R5: every bit, both polarities, one-hot and inverse status
        for (int s = 0; s < 8; s++) begin
            apply(1, 1000, 2, 10, 1 << s, s, 1, 0, 0);
            apply(1, 1000, 2, 10, 1 << s, s, 0, 0, 0);
            apply(1, 1000, 2, 10, 8'hFF ^ (1 << s), s, 1, 0, 0);
        end
        // R6: N^V with stored bit 4 contradicting
        apply(1, 500, 2, 8, 8'h1C, 4, 0, 0, 0);   // N=1 V=1 -> GE taken
        apply(1, 500, 2, 8, 8'h1C, 4, 1, 0, 0);   // LT not taken
        apply(1, 500, 2, 8, 8'h04, 4, 1, 0, 0);   // N=1 V=0 -> LT taken
        apply(1, 500, 2, 8, 8'h14, 4, 0, 0, 0);   // GE not taken
        // R7: upper offset bits ignored, negative 7-bit offset, wrap below zero
        apply(1, 300, 2, 12'hF85, 8'h01, 0, 1, 0, 0);
        apply(1, 10, 2, 12'h07F ^ 12'h400, 8'h02, 1, 1, 0, 0);
        apply(1, 5, 2, 12'h040, 8'h02, 1, 1, 0, 0);
        // R8 not taken with big offset
        apply(1, 4095, 2, 12'hFFF, 8'h00, 1, 1, 0, 0);
        // R9 all skip lengths, plus wrap
        apply(1, 600, 3, 50, 8'hFF, 2, 1, 0, 1);
        apply(1, 600, 3, 50, 0, 0, 0, 1, 0);
        apply(1, 600, 3, 50, 0, 0, 0, 1, 1);
        apply(1, 4094, 3, 0, 0, 0, 0, 1, 1);
        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            apply(($urandom % 8) != 0, $urandom % 4096, $urandom % 4, $urandom % 4096,
                  $urandom % 256, $urandom % 8, 1'($urandom % 2),
                  1'($urandom % 2), 1'($urandom % 2));
        end
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule